// File: doc/BRIEF.md
# Post-Increment Load Datapath Slice

This block is a small multicycle processor slice. It fetches 8-bit instructions from one shared memory and executes a single real instruction: a register-indirect load that also advances its address register. Any other opcode is treated as a no-operation. The slice holds a program counter, an instruction register, a four-entry register file, a memory data register and an ALU result register. A finite-state controller steers the register-write selector and the first ALU operand selector.

Every instruction spends its first cycle on fetch and its second on reading two registers. A load then needs three more cycles, with one step in each:

- read memory at the base register and form the base plus one;
- write the loaded byte to the destination register;
- write the incremented address back to the base register.

The file has only one write port, so the two results are committed in separate cycles. The address write-back comes last. When the destination and base fields name the same register, that register therefore ends up holding the old address plus one. A one-cycle `retire` pulse marks the last cycle of each instruction. The architectural state is brought out on ports so that a surrounding environment can compare it against a model.

Top module: `pil_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC and all four registers are cleared to 0 and the controller returns to fetch. In the first cycle after reset, `mem_addr` is 0 and `retire` is 0.
- R2: In the first cycle of every instruction, `mem_addr` equals the PC and `retire` is 0. At the end of that cycle the byte read becomes the instruction and the PC advances by 1, wrapping from 0xFF to 0x00.
- R3: The instruction fields are: bits 7:6 name the destination register, bits 5:4 name the base register, and bits 3:0 hold the opcode. An opcode other than 0 retires in its second cycle (`retire` high) and leaves all registers unchanged.
- R4: For opcode 0 (load), `mem_addr` in the third cycle equals the value that the base register held when the instruction began.
- R5: In the fifth cycle of a load, the destination register already holds the memory byte read in the third cycle.
- R6: In the fifth cycle of a load, a base register distinct from the destination still holds its old value. At the end of that cycle it becomes the old value plus 1, wrapping 0xFF to 0x00. A load takes exactly five cycles, and `retire` is high only in the fifth.
- R7: When the destination and base fields are equal, that register ends the load holding its original value plus 1, not the loaded byte.
- R8: Registers that are named by neither field of an instruction are never modified by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Address to the shared instruction/data memory |
| mem_rdata | input | 8 | Byte returned by memory for `mem_addr` in the same cycle |
| retire | output | 1 | High during the final cycle of each instruction |
| pc | output | 8 | Current program counter |
| regs_flat | output | 32 | Register file contents, register k at bits 8k+7:8k |

## Verification
The two results of a load cannot be written in the same cycle. The hazard lies in which of them lands last when both target one register. Directed aliased loads have the destination field equal to the base field, and random programs biased towards loads produce many more of them. In each case the final register value must be the base plus one, and never the loaded byte or the loaded byte plus one. The bench also samples the fifth cycle, where the loaded byte must already be present while a distinct base register still holds its old value. This proves the data write comes first and the address write-back follows.

// File: rtl/pil_pkg.sv
// Package: shared types for the post-increment load slice.
// Assumes an 8-bit instruction of {dest[1:0], base[1:0], opcode[3:0]}.
package pil_pkg;
    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_RDREG  = 3'd1,
        ST_MEMRD  = 3'd2,
        ST_WRDATA = 3'd3,
        ST_WRBASE = 3'd4
    } pil_state_e;

    typedef enum logic [1:0] {
        RW_DST  = 2'd0,
        RW_BASE = 2'd1,
        RW_ONE  = 2'd2
    } pil_rwsel_e;

    typedef enum logic [1:0] {
        A1_PC = 2'd0,
        A1_RA = 2'd1,
        A1_RB = 2'd2
    } pil_alu1_e;

    typedef enum logic {
        AD_PC   = 1'b0,
        AD_BASE = 1'b1
    } pil_addr_e;

    localparam logic [3:0] OP_LOAD = 4'h0;
endpackage

// File: rtl/pil_regfile.sv
// Module: register file with two combinational read ports and one write port.
// Assumes a synchronous active-low reset clears every entry to zero.
module pil_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int RAW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [RAW-1:0]     waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [RAW-1:0]     raddr_a,
    input  logic [RAW-1:0]     raddr_b,
    output logic [DW-1:0]      rdata_a,
    output logic [DW-1:0]      rdata_b,
    output logic [NREG*DW-1:0] regs_flat
);
    logic [DW-1:0] entry [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_entry
        // Hold one register; load it when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[k] <= '0;
            else if (we && (waddr == RAW'(k)))
                entry[k] <= wdata;
        end
        assign regs_flat[k*DW +: DW] = entry[k];
    end

    // Read both ports straight from the storage.
    always_comb begin
        rdata_a = entry[raddr_a];
        rdata_b = entry[raddr_b];
    end
endmodule

// File: rtl/pil_alu.sv
// Module: ALU operand select and incrementer.
// Assumes the second operand is always the constant one (only additions of 1 are needed).
module pil_alu
    import pil_pkg::*;
#(
    parameter int DW = 8
) (
    input  pil_alu1_e     sel1,
    input  logic [DW-1:0] pc_val,
    input  logic [DW-1:0] ra_val,
    input  logic [DW-1:0] rb_val,
    output logic [DW-1:0] sum
);
    logic [DW-1:0] op1;

    // Pick the first operand and add one, modulo 2^DW.
    always_comb begin
        unique case (sel1)
            A1_RA:   op1 = ra_val;
            A1_RB:   op1 = rb_val;
            default: op1 = pc_val;
        endcase
        sum = op1 + DW'(1);
    end
endmodule

// File: rtl/pil_ctrl.sv
// Module: multicycle controller. Fetch, read registers, then either retire
// (any non-load opcode) or run the three load steps.
// Assumes the opcode input is stable from the second cycle on (IR loads only in fetch).
module pil_ctrl
    import pil_pkg::*;
#(
    parameter int OPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    output pil_state_e     state,
    output logic           ir_load,
    output logic           pc_load,
    output logic           ab_load,
    output logic           mem_load,
    output logic           rf_we,
    output logic           wd_alu,
    output pil_rwsel_e     rwsel,
    output pil_alu1_e      alu1_sel,
    output pil_addr_e      addr_sel,
    output logic           retire
);
    logic is_load;
    assign is_load = (opcode == OPW'(OP_LOAD));

    // Advance the state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_FETCH;
        else begin
            unique case (state)
                ST_FETCH:  state <= ST_RDREG;
                ST_RDREG:  state <= is_load ? ST_MEMRD : ST_FETCH;
                ST_MEMRD:  state <= ST_WRDATA;
                ST_WRDATA: state <= ST_WRBASE;
                default:   state <= ST_FETCH;
            endcase
        end
    end

    // Decode the state into datapath controls.
    always_comb begin
        ir_load  = (state == ST_FETCH);
        pc_load  = (state == ST_FETCH);
        ab_load  = (state == ST_RDREG);
        mem_load = (state == ST_MEMRD);
        rf_we    = (state == ST_WRDATA) || (state == ST_WRBASE);
        wd_alu   = (state == ST_WRBASE);
        rwsel    = (state == ST_WRBASE) ? RW_BASE : RW_DST;
        alu1_sel = (state == ST_MEMRD) ? A1_RB : A1_PC;
        addr_sel = (state == ST_MEMRD) ? AD_BASE : AD_PC;
        retire   = (state == ST_WRBASE) || ((state == ST_RDREG) && !is_load);
    end

    // R3
    nop_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDREG && !is_load) |=> (state == ST_FETCH));
    // R6
    load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEMRD) |=> (state == ST_WRDATA));
    // R6
    wb_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRDATA) |=> (state == ST_WRBASE && retire));
    // R2
    retire_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (state == ST_FETCH && !retire));
endmodule

// File: rtl/pil_core.sv
// Module: top of the post-increment load slice. Holds PC, IR, the latched read
// values, MDR and the ALU result register, and wires controller, ALU and file.
// Assumes memory answers mem_addr with mem_rdata in the same cycle.
module pil_core
    import pil_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int RAW = $clog2(NREG),
    localparam int OPW = DW - 2*RAW
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [DW-1:0]      mem_addr,
    input  logic [DW-1:0]      mem_rdata,
    output logic               retire,
    output logic [DW-1:0]      pc,
    output logic [NREG*DW-1:0] regs_flat
);
    logic [DW-1:0]  ir, a_q, b_q, mdr, aluout, alu_sum, rd_a, rd_b, wdata;
    logic [RAW-1:0] dst_f, base_f, waddr;
    logic [OPW-1:0] op_f;
    pil_state_e     state;
    pil_rwsel_e     rwsel;
    pil_alu1_e      alu1_sel;
    pil_addr_e      addr_sel;
    logic           ir_load, pc_load, ab_load, mem_load, rf_we, wd_alu;

    assign dst_f  = ir[DW-1 -: RAW];
    assign base_f = ir[DW-1-RAW -: RAW];
    assign op_f   = ir[OPW-1:0];

    pil_ctrl #(.OPW(OPW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(op_f), .state(state),
        .ir_load(ir_load), .pc_load(pc_load), .ab_load(ab_load),
        .mem_load(mem_load), .rf_we(rf_we), .wd_alu(wd_alu),
        .rwsel(rwsel), .alu1_sel(alu1_sel), .addr_sel(addr_sel),
        .retire(retire)
    );

    pil_alu #(.DW(DW)) u_alu (
        .sel1(alu1_sel), .pc_val(pc), .ra_val(a_q), .rb_val(b_q), .sum(alu_sum)
    );

    // Select the write register from the two IR fields or the constant register 1.
    always_comb begin
        unique case (rwsel)
            RW_BASE: waddr = base_f;
            RW_ONE:  waddr = RAW'(1);
            default: waddr = dst_f;
        endcase
        wdata    = wd_alu ? aluout : mdr;
        mem_addr = (addr_sel == AD_BASE) ? b_q : pc;
    end

    pil_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(waddr), .wdata(wdata),
        .raddr_a(dst_f), .raddr_b(base_f), .rdata_a(rd_a), .rdata_b(rd_b),
        .regs_flat(regs_flat)
    );

    // Program counter and instruction register update during fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else if (pc_load) begin
            pc <= alu_sum;
            if (ir_load) ir <= mem_rdata;
        end
    end

    // Latch both register reads, then the memory byte and the incremented base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mdr    <= '0;
            aluout <= '0;
        end else begin
            if (ab_load) begin
                a_q <= rd_a;
                b_q <= rd_b;
            end
            if (mem_load) begin
                mdr    <= mem_rdata;
                aluout <= alu_sum;
            end
        end
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1));
    // R6
    inc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEMRD) |=> (aluout == $past(b_q) + 1'b1 && mdr == $past(mem_rdata)));
    // R5
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRDATA) |=> (regs_flat[dst_f*DW +: DW] == $past(mdr)));
    // R7
    base_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRBASE) |=> (regs_flat[base_f*DW +: DW] == $past(aluout)));
endmodule

// File: tb/sim_pil_core.sv
`timescale 1ns/1ps
module sim_pil_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr, mem_rdata, pc;
    logic        retire;
    logic [31:0] regs_flat;
    logic [7:0]  mem [256];
    logic [7:0]  rf [4];
    logic [7:0]  ref_pc;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    localparam int NINSTR = 3000;

    always #2 clk = ~clk;

    pil_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .retire(retire), .pc(pc), .regs_flat(regs_flat)
    );

    assign mem_rdata = mem[mem_addr];

    function automatic logic [31:0] pack_ref();
        return {rf[3], rf[2], rf[1], rf[0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ins, addr;
        logic [1:0] dst, bs;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom);
            if ($urandom_range(1, 0) == 1) mem[i][3:0] = 4'h0;
        end
        mem[0]    = 8'h50;  // r1 <- mem[r1], r1 += 1 (aliased)
        mem[1]    = 8'h90;  // r2 <- mem[r1]
        mem[2]    = 8'h05;  // no-op
        mem[3]    = 8'hE0;  // r3 <- mem[r2]
        mem[4]    = 8'h30;  // r0 <- mem[r3], r3 = 0xFF + 1 wraps
        mem[5]    = 8'hF0;  // aliased r3
        mem[8'h90] = 8'hFF;
        for (int k = 0; k < 4; k++) rf[k] = 8'h00;
        ref_pc = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 pc", {24'h0, pc}, 32'h0);
        chk("R1 regs", regs_flat, 32'h0);
        chk("R1 retire", {31'h0, retire}, 32'h0);
        chk("R1 addr", {24'h0, mem_addr}, 32'h0);

        for (int n = 0; n < NINSTR; n++) begin
            ins = mem[ref_pc];
            dst = ins[7:6];
            bs  = ins[5:4];
            chk("R2 addr", {24'h0, mem_addr}, {24'h0, ref_pc});
            chk("R2 retire", {31'h0, retire}, 32'h0);
            @(negedge clk);
            chk("R2 pc", {24'h0, pc}, {24'h0, 8'(ref_pc + 8'd1)});
            ref_pc = ref_pc + 8'd1;
            if (ins[3:0] != 4'h0) begin
                chk("R3 retire", {31'h0, retire}, 32'h1);
                @(negedge clk);
                chk("R3 regs", regs_flat, pack_ref());
            end else begin
                chk("R6 c2", {31'h0, retire}, 32'h0);
                @(negedge clk);
                addr = rf[bs];
                chk("R4 addr", {24'h0, mem_addr}, {24'h0, addr});
                chk("R6 c3", {31'h0, retire}, 32'h0);
                @(negedge clk);
                chk("R6 c4", {31'h0, retire}, 32'h0);
                @(negedge clk);
                chk("R6 c5", {31'h0, retire}, 32'h1);
                chk("R5 data", {24'h0, regs_flat[dst*8 +: 8]}, {24'h0, mem[addr]});
                if (dst != bs)
                    chk("R6 order", {24'h0, regs_flat[bs*8 +: 8]}, {24'h0, addr});
                rf[dst] = mem[addr];
                rf[bs]  = addr + 8'd1;
                @(negedge clk);
                if (dst == bs)
                    chk("R7 alias", {24'h0, regs_flat[bs*8 +: 8]}, {24'h0, 8'(addr + 8'd1)});
                else
                    chk("R6 base", {24'h0, regs_flat[bs*8 +: 8]}, {24'h0, 8'(addr + 8'd1)});
                chk("R8 regs", regs_flat, pack_ref());
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule